// File: doc/BRIEF.md
# PTP Event Frame Generator (Layer-2 Offload)

This block builds precision-time-protocol version 2 event frames in hardware and streams them out byte by byte, so software never assembles them. The frames travel straight inside an Ethernet frame with EtherType 0x88F7, with no IP or UDP layer. On a time master the block sends Sync frames on its own, at an interval given as a signed power of two of one second. On a time slave it answers received Sync frames with Delay_Req frames, optionally sending only one for every 2^k Syncs.

Each frame is one-step. The time value on the free-running timestamp inputs is sampled when the frame starts and written into the frame itself, so no Follow_Up frame is needed. When a slave finishes sending a Delay_Req, the block raises a one-cycle interrupt and holds that same time value (t2) on dedicated outputs. Sync frames raise no interrupt.

Configuration comes from plain inputs:
- an offload enable, a mode bit and an auto-Sync enable;
- the domain number and the log interval;
- the thinning exponent;
- the source MAC address and an 80-bit port identity.

The identity is supplied as two 32-bit words and a 16-bit extension. The interval timer counts pulses of a fixed-rate tick enable. The block assumes software changes the configuration only while no frame is being sent.

Top module: `ptp_evt_gen`

## Requirements
- R1: Every frame is 58 bytes and carries no IP or UDP layer. Bytes 0-5 hold the destination 01-1B-19-00-00-00, bytes 6-11 hold `cfg_src_mac` (most significant byte first), and bytes 12-13 hold 0x88 then 0xF7.
- R2: Bytes 14-33 form the start of the PTP header:
  - byte 14 is 0x00 for Sync and 0x01 for Delay_Req;
  - byte 15 is 0x02;
  - bytes 16-17 are 0x002C;
  - byte 18 is `cfg_domain`;
  - bytes 19-33 are zero, so the two-step flag is clear and the correction is zero.
- R3: Bytes 34-43 hold the port identity `{cfg_id_hi, cfg_id_lo, cfg_id_ext}`, most significant byte first.
- R4: Bytes 44-45 hold the sequence number, most significant byte first. Sync and Delay_Req use separate 16-bit counters. Each counter starts at 0 after reset and advances by one (modulo 2^16) after each frame of its type.
- R5: Byte 46 is 0x00 for Sync and 0x01 for Delay_Req. Byte 47 is `cfg_log_intvl` for Sync and 0x7F for Delay_Req.
- R6: Bytes 48-57 hold `{ts_sec, ts_ns}`, most significant byte first, as sampled at the clock edge just before the first byte appears.
- R7: Sync frames are sent only while `cfg_offload_en`, `cfg_auto_sync` and `cfg_master` are all 1. Consecutive Sync frames start P tick pulses apart. P is TICK_HZ >> -n for a negative log value n, and TICK_HZ << n otherwise. With either enable clear, no Sync is sent.
- R8: With `cfg_offload_en`=1 and `cfg_master`=0, one Delay_Req is sent for every 2^`cfg_dreq_ratio` pulses of `rx_sync_seen`. Ratio 0 gives one per Sync and ratio 1 gives one per two. No Delay_Req is sent in master mode or while offload is disabled.
- R9: `ts_irq` pulses high for exactly the one cycle after the last byte of a Delay_Req frame. In that cycle `{t2_sec, t2_ns}` equal that frame's bytes 48-57. It never pulses for a Sync frame.
- R10: `tx_valid` is low after reset. Within a frame `tx_valid` stays high for 58 consecutive cycles, and `tx_last` is high only with the 58th byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Fixed-rate tick, TICK_HZ pulses per second |
| cfg_offload_en | input | 1 | Master enable for frame generation |
| cfg_master | input | 1 | 1 = time master (Sync), 0 = slave (Delay_Req) |
| cfg_auto_sync | input | 1 | Enables periodic Sync generation |
| cfg_domain | input | 8 | Domain number written into every frame |
| cfg_log_intvl | input | 8 | Signed log2 of the Sync interval in seconds |
| cfg_dreq_ratio | input | RATIO_W | Thinning exponent: one Delay_Req per 2^value Syncs |
| cfg_id_lo | input | 32 | Port identity, middle word |
| cfg_id_hi | input | 32 | Port identity, leading word |
| cfg_id_ext | input | 16 | Port identity, trailing 16 bits |
| cfg_src_mac | input | 48 | Source MAC address |
| rx_sync_seen | input | 1 | One-cycle pulse per received Sync |
| ts_sec | input | 48 | Free-running time, seconds |
| ts_ns | input | 32 | Free-running time, nanoseconds |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Byte valid |
| tx_last | output | 1 | Last byte of frame |
| ts_irq | output | 1 | Delay_Req transmit-timestamp interrupt |
| t2_sec | output | 48 | Captured Delay_Req time, seconds |
| t2_ns | output | 32 | Captured Delay_Req time, nanoseconds |

## Verification
The assertions check the stream framing on every cycle:
- a 58-byte length, with no gap inside a frame and `tx_last` only with a valid byte;
- the fixed EtherType and version bytes at their offsets;
- the rule that the interrupt follows only the last byte of a Delay_Req.

Other behaviour appears only in the bench's scenarios: the per-type sequence counting, the one-step timestamp, the Sync spacing for each log value, the enable gating and the Delay_Req thinning for each ratio. These depend on the history of the configuration and of received Syncs, so the bench compares each whole frame and each count of frames against a model.

// File: rtl/ptp_evt_pkg.sv
package ptp_evt_pkg;

   localparam int ETH_HDR_BYTES = 14;
   localparam int PTP_HDR_BYTES = 34;
   localparam int TS_BYTES      = 10;
   localparam int FRAME_BYTES   = ETH_HDR_BYTES + PTP_HDR_BYTES + TS_BYTES;
   localparam int PTP_LEN       = PTP_HDR_BYTES + TS_BYTES;

   localparam logic [15:0] ETYPE_PTP  = 16'h88F7;
   localparam logic [47:0] DST_MCAST  = 48'h011B19000000;
   localparam logic [7:0]  PTP_VER    = 8'h02;
   localparam logic [7:0]  DREQ_LOGIV = 8'h7F;

   typedef enum logic [3:0] {
      MSG_SYNC = 4'h0,
      MSG_DREQ = 4'h1
   } msg_e;

   typedef struct packed {
      logic [47:0] sec;
      logic [31:0] ns;
   } ptp_ts_t;

endpackage

// File: rtl/ptp_sync_timer.sv
module ptp_sync_timer #(
   parameter int TICK_HZ = 512,
   parameter int LOG_LIM = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic signed [7:0] log_intvl,
   output logic              due
);

   localparam int CNT_W = $clog2(TICK_HZ + 1) + LOG_LIM;
   localparam logic [CNT_W-1:0] BASE = CNT_W'(TICK_HZ);

   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] cnt;

   // clamp the log value, then scale one second of ticks
   always_comb begin
      int lg;
      lg = int'(log_intvl);
      if (lg > LOG_LIM)       lg = LOG_LIM;
      else if (lg < -LOG_LIM) lg = -LOG_LIM;
      if (lg < 0) period = BASE >> (-lg);
      else        period = BASE << lg;
      if (period == '0) period = CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         due <= 1'b0;
      end else begin
         due <= 1'b0;
         if (!run) begin
            cnt <= '0;
         end else if (tick) begin
            if (cnt >= period - CNT_W'(1)) begin
               cnt <= '0;
               due <= 1'b1;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/ptp_dreq_thin.sv
module ptp_dreq_thin #(
   parameter int RATIO_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               sync_seen,
   input  logic [RATIO_W-1:0] ratio,
   output logic               req
);

   localparam int CNT_W = (1 << RATIO_W) - 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   assign limit = {CNT_W{1'b1}} >> (CNT_W - int'(ratio));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         req <= 1'b0;
      end else begin
         req <= 1'b0;
         if (!run) begin
            cnt <= '0;
         end else if (sync_seen) begin
            if (cnt >= limit) begin
               cnt <= '0;
               req <= 1'b1;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/ptp_frame_tx.sv
module ptp_frame_tx
   import ptp_evt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_run,
   input  logic              dreq_run,
   input  logic              sync_req,
   input  logic              dreq_req,
   input  logic [7:0]        domain,
   input  logic signed [7:0] log_intvl,
   input  logic [31:0]       id_hi,
   input  logic [31:0]       id_lo,
   input  logic [15:0]       id_ext,
   input  logic [47:0]       src_mac,
   input  ptp_ts_t           ts_now,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   output logic              tx_last,
   output logic              irq,
   output ptp_ts_t           irq_ts,
   output logic              cur_dreq
);

   localparam int IDX_W = $clog2(FRAME_BYTES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

   logic              busy;
   logic [IDX_W-1:0]  idx;
   logic              sync_pend;
   logic              dreq_pend;
   logic              lat_dreq;
   ptp_ts_t           lat_ts;
   logic [15:0]       lat_seq;
   logic [15:0]       seq_sync;
   logic [15:0]       seq_dreq;
   logic              start_sync;
   logic              start_dreq;
   logic              at_end;

   assign start_sync = !busy && sync_pend;
   assign start_dreq = !busy && dreq_pend && !sync_pend;
   assign at_end     = busy && (idx == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         idx       <= '0;
         sync_pend <= 1'b0;
         dreq_pend <= 1'b0;
         lat_dreq  <= 1'b0;
         lat_ts    <= '0;
         lat_seq   <= '0;
         seq_sync  <= '0;
         seq_dreq  <= '0;
         irq       <= 1'b0;
         irq_ts    <= '0;
      end else begin
         sync_pend <= sync_run && ((sync_pend && !start_sync) || sync_req);
         dreq_pend <= dreq_run && ((dreq_pend && !start_dreq) || dreq_req);
         irq       <= at_end && lat_dreq;
         if (at_end && lat_dreq) irq_ts <= lat_ts;
         if (start_sync || start_dreq) begin
            busy     <= 1'b1;
            idx      <= '0;
            lat_dreq <= start_dreq;
            lat_ts   <= ts_now;
            lat_seq  <= start_dreq ? seq_dreq : seq_sync;
         end else if (busy) begin
            if (at_end) begin
               busy <= 1'b0;
               idx  <= '0;
               if (lat_dreq) seq_dreq <= seq_dreq + 16'd1;
               else          seq_sync <= seq_sync + 16'd1;
            end else begin
               idx <= idx + IDX_W'(1);
            end
         end
      end
   end

   // frame image, first byte in the top bits
   logic [FRAME_BYTES*8-1:0] frame;
   msg_e                     mtype;
   logic [7:0]               ctrl;
   logic [7:0]               logb;

   always_comb begin
      mtype = lat_dreq ? MSG_DREQ : MSG_SYNC;
      ctrl  = lat_dreq ? 8'h01 : 8'h00;
      logb  = lat_dreq ? DREQ_LOGIV : log_intvl;
      frame = {DST_MCAST, src_mac, ETYPE_PTP,
               4'h0, mtype, PTP_VER, 16'(PTP_LEN), domain, 8'h00,
               16'h0000, 64'h0, 32'h0,
               id_hi, id_lo, id_ext,
               lat_seq, ctrl, logb,
               lat_ts.sec, lat_ts.ns};
   end

   logic [7:0] fbyte [FRAME_BYTES];

   for (genvar b = 0; b < FRAME_BYTES; b++) begin : g_byte
      assign fbyte[b] = frame[(FRAME_BYTES-1-b)*8 +: 8];
   end

   assign tx_data  = busy ? fbyte[idx] : 8'h00;
   assign tx_valid = busy;
   assign tx_last  = at_end;
   assign cur_dreq = lat_dreq;

endmodule

// File: rtl/ptp_evt_gen.sv
module ptp_evt_gen
   import ptp_evt_pkg::*;
#(
   parameter int TICK_HZ = 512,
   parameter int LOG_LIM = 4,
   parameter int RATIO_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_en,
   input  logic               cfg_offload_en,
   input  logic               cfg_master,
   input  logic               cfg_auto_sync,
   input  logic [7:0]         cfg_domain,
   input  logic signed [7:0]  cfg_log_intvl,
   input  logic [RATIO_W-1:0] cfg_dreq_ratio,
   input  logic [31:0]        cfg_id_lo,
   input  logic [31:0]        cfg_id_hi,
   input  logic [15:0]        cfg_id_ext,
   input  logic [47:0]        cfg_src_mac,
   input  logic               rx_sync_seen,
   input  logic [47:0]        ts_sec,
   input  logic [31:0]        ts_ns,
   output logic [7:0]         tx_data,
   output logic               tx_valid,
   output logic               tx_last,
   output logic               ts_irq,
   output logic [47:0]        t2_sec,
   output logic [31:0]        t2_ns
);

   if (TICK_HZ < 2) begin : g_bad_tick
      $error("ptp_evt_gen: TICK_HZ must be at least 2");
   end
   if (LOG_LIM < 0 || LOG_LIM > 16) begin : g_bad_log
      $error("ptp_evt_gen: LOG_LIM must lie in 0..16");
   end
   if (RATIO_W < 1 || RATIO_W > 4) begin : g_bad_ratio
      $error("ptp_evt_gen: RATIO_W must lie in 1..4");
   end

   logic    sync_run;
   logic    dreq_run;
   logic    sync_due;
   logic    dreq_due;
   logic    frame_is_dreq;
   ptp_ts_t ts_now;
   ptp_ts_t t2_val;

   assign sync_run = cfg_offload_en && cfg_auto_sync && cfg_master;
   assign dreq_run = cfg_offload_en && !cfg_master;
   assign ts_now   = '{sec: ts_sec, ns: ts_ns};

   ptp_sync_timer #(
      .TICK_HZ (TICK_HZ),
      .LOG_LIM (LOG_LIM)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (sync_run),
      .tick      (tick_en),
      .log_intvl (cfg_log_intvl),
      .due       (sync_due)
   );

   ptp_dreq_thin #(
      .RATIO_W (RATIO_W)
   ) u_thin (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (dreq_run),
      .sync_seen (rx_sync_seen),
      .ratio     (cfg_dreq_ratio),
      .req       (dreq_due)
   );

   ptp_frame_tx u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_run  (sync_run),
      .dreq_run  (dreq_run),
      .sync_req  (sync_due),
      .dreq_req  (dreq_due),
      .domain    (cfg_domain),
      .log_intvl (cfg_log_intvl),
      .id_hi     (cfg_id_hi),
      .id_lo     (cfg_id_lo),
      .id_ext    (cfg_id_ext),
      .src_mac   (cfg_src_mac),
      .ts_now    (ts_now),
      .tx_data   (tx_data),
      .tx_valid  (tx_valid),
      .tx_last   (tx_last),
      .irq       (ts_irq),
      .irq_ts    (t2_val),
      .cur_dreq  (frame_is_dreq)
   );

   assign t2_sec = t2_val.sec;
   assign t2_ns  = t2_val.ns;

endmodule

// File: rtl/ptp_evt_gen_chk.sv
module ptp_evt_gen_chk
   import ptp_evt_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] tx_data,
   input logic       tx_valid,
   input logic       tx_last,
   input logic       ts_irq,
   input logic       cur_dreq
);

   localparam int CW = $clog2(FRAME_BYTES + 1);

   logic [CW-1:0] nbytes;

   always_ff @(posedge clk) begin
      if (!rst_n)        nbytes <= '0;
      else if (tx_valid) nbytes <= tx_last ? '0 : nbytes + CW'(1);
   end

   p_last_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   p_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> (nbytes == CW'(FRAME_BYTES - 1)));

   p_no_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_last) |=> tx_valid);

   p_etype_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && nbytes == CW'(12)) |-> (tx_data == ETYPE_PTP[15:8]));

   p_etype_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && nbytes == CW'(13)) |-> (tx_data == ETYPE_PTP[7:0]));

   p_version_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && nbytes == CW'(15)) |-> (tx_data == PTP_VER));

   p_irq_dreq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ts_irq |-> $past(tx_last && cur_dreq));

endmodule

bind ptp_evt_gen ptp_evt_gen_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_data  (tx_data),
   .tx_valid (tx_valid),
   .tx_last  (tx_last),
   .ts_irq   (ts_irq),
   .cur_dreq (frame_is_dreq)
);

// File: tb/test_ptp_evt_gen.sv
module test_ptp_evt_gen;

   localparam int CLK_PERIOD = 10;
   localparam int TICK_HZ    = 512;
   localparam int NB         = 58;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b1;
   logic        cfg_offload_en = 1'b0;
   logic        cfg_master = 1'b0;
   logic        cfg_auto_sync = 1'b0;
   logic [7:0]  cfg_domain = '0;
   logic [7:0]  cfg_log_intvl = '0;
   logic [2:0]  cfg_dreq_ratio = '0;
   logic [31:0] cfg_id_lo = '0;
   logic [31:0] cfg_id_hi = '0;
   logic [15:0] cfg_id_ext = '0;
   logic [47:0] cfg_src_mac = '0;
   logic        rx_sync_seen = 1'b0;
   logic [47:0] ts_sec = '0;
   logic [31:0] ts_ns = '0;
   logic [7:0]  tx_data;
   logic        tx_valid;
   logic        tx_last;
   logic        ts_irq;
   logic [47:0] t2_sec;
   logic [31:0] t2_ns;

   ptp_evt_gen #(.TICK_HZ(TICK_HZ)) i_ptp_evt_gen (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .cfg_offload_en(cfg_offload_en), .cfg_master(cfg_master),
      .cfg_auto_sync(cfg_auto_sync), .cfg_domain(cfg_domain),
      .cfg_log_intvl(cfg_log_intvl), .cfg_dreq_ratio(cfg_dreq_ratio),
      .cfg_id_lo(cfg_id_lo), .cfg_id_hi(cfg_id_hi), .cfg_id_ext(cfg_id_ext),
      .cfg_src_mac(cfg_src_mac), .rx_sync_seen(rx_sync_seen),
      .ts_sec(ts_sec), .ts_ns(ts_ns), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_last(tx_last), .ts_irq(ts_irq),
      .t2_sec(t2_sec), .t2_ns(t2_ns));

   initial forever #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model state
   int          m_log = 0;
   int          m_period = TICK_HZ;
   bit          m_master = 0;
   logic [15:0] m_seq_sync = 0;
   logic [15:0] m_seq_dreq = 0;
   int          n_sync = 0;
   int          n_dreq = 0;
   int          n_irq = 0;
   longint      cyc = 0;
   longint      prev_start = 0;
   bit          prev_ok = 0;
   bit          irq_due = 0;
   logic [79:0] exp_t2 = 0;

   task automatic chk(bit ok, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic int period_of(int lg);
      if (lg < 0) return TICK_HZ >> (-lg);
      return TICK_HZ << lg;
   endfunction

   function automatic string tag_of(int i);
      if (i < 14) return "R1 eth header";
      if (i < 34) return "R2 ptp header";
      if (i < 44) return "R3 port identity";
      if (i < 46) return "R4 sequence";
      if (i < 48) return "R5 control/log";
      return "R6 origin timestamp";
   endfunction

   function automatic logic [7:0] exp_byte(int i, bit dreq, logic [15:0] seq,
                                           logic [79:0] ts);
      logic [NB*8-1:0] f;
      f = {48'h011B19000000, cfg_src_mac, 8'h88, 8'hF7,
           (dreq ? 8'h01 : 8'h00), 8'h02, 8'h00, 8'h2C, cfg_domain,
           120'h0,
           cfg_id_hi, cfg_id_lo, cfg_id_ext,
           seq, (dreq ? 8'h01 : 8'h00), (dreq ? 8'h7F : 8'(m_log)),
           ts};
      return f[(NB-1-i)*8 +: 8];
   endfunction

   // monitor: samples outputs at the falling edge, then advances time input
   initial begin
      logic [7:0]  fb [NB];
      int          nb = 0;
      bit          in_frame = 0;
      logic [79:0] f_ts = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (irq_due) begin
               chk(ts_irq === 1'b1, "R9 irq pulse after Delay_Req", ts_irq, 1);
               chk({t2_sec, t2_ns} == exp_t2, "R9 captured t2", {t2_sec, t2_ns}, exp_t2);
               if (ts_irq) n_irq++;
               irq_due = 0;
            end else if (ts_irq) begin
               chk(0, "R9 stray interrupt", 1, 0);
            end
            if (in_frame && !tx_valid) begin
               chk(0, "R10 gap inside frame", nb, NB);
               in_frame = 0;
               nb = 0;
            end
            if (tx_valid) begin
               if (nb == 0) begin
                  f_ts = {ts_sec, ts_ns};
                  in_frame = 1;
                  if (m_master) begin
                     n_sync++;
                     if (prev_ok)
                        chk(cyc - prev_start == m_period, "R7 Sync spacing",
                            cyc - prev_start, m_period);
                     prev_start = cyc;
                     prev_ok = 1;
                  end else begin
                     n_dreq++;
                  end
               end
               if (nb < NB) fb[nb] = tx_data;
               if (tx_last || nb == NB) begin
                  chk(nb == NB - 1 && tx_last, "R10 frame length", nb + 1, NB);
                  for (int i = 0; i < NB; i++) begin
                     logic [7:0] e;
                     e = exp_byte(i, !m_master, m_master ? m_seq_sync : m_seq_dreq, f_ts);
                     chk(fb[i] == e, tag_of(i), fb[i], e);
                  end
                  if (m_master) m_seq_sync++;
                  else begin
                     m_seq_dreq++;
                     irq_due = 1;
                     exp_t2 = f_ts;
                  end
                  nb = 0;
                  in_frame = 0;
               end else begin
                  nb++;
               end
            end
         end
         cyc++;
         ts_ns = ts_ns + 32'd7;
      end
   end

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog for all requirements actual=timeout expected=finished");
         finish_sim();
      end
   end

   task automatic pulse_rx();
      rx_sync_seen = 1'b1;
      @(negedge clk);
      rx_sync_seen = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h1234_5EED));
      repeat (4) @(negedge clk);
      chk(tx_valid == 1'b0, "R10 no frame in reset", tx_valid, 0);
      chk(ts_irq == 1'b0, "R9 no irq in reset", ts_irq, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // master rounds with random identity and interval
      for (int r = 0; r < 4; r++) begin
         cfg_domain    = 8'($urandom);
         cfg_src_mac   = {16'($urandom), 32'($urandom)};
         cfg_id_hi     = $urandom;
         cfg_id_lo     = $urandom;
         cfg_id_ext    = (r == 0) ? 16'hCAFE : 16'($urandom);
         ts_sec        = {16'($urandom), 32'($urandom)};
         m_log         = (r == 3) ? 0 : -1 - int'($urandom % 3);
         m_period      = period_of(m_log);
         cfg_log_intvl = 8'(m_log);
         m_master      = 1;
         cfg_master    = 1'b1;
         cfg_auto_sync = 1'b1;
         prev_ok       = 0;
         n_sync        = 0;
         n_dreq        = 0;
         cfg_offload_en = 1'b1;
         repeat (50) @(negedge clk);
         pulse_rx();
         repeat (4 * m_period + m_period / 2 - 51) @(negedge clk);
         cfg_offload_en = 1'b0;
         repeat (80) @(negedge clk);
         chk(n_sync == 4, "R7 Sync count in window", n_sync, 4);
         chk(n_dreq == 0, "R8 no Delay_Req in master", n_dreq, 0);
      end

      // enable gating for Sync
      n_sync = 0;
      cfg_auto_sync = 1'b0;
      cfg_offload_en = 1'b1;
      repeat (600) @(negedge clk);
      chk(n_sync == 0, "R7 no Sync without auto enable", n_sync, 0);
      cfg_auto_sync = 1'b1;
      cfg_offload_en = 1'b0;
      repeat (600) @(negedge clk);
      chk(n_sync == 0, "R7 no Sync without offload enable", n_sync, 0);
      cfg_auto_sync = 1'b0;

      // slave rounds with thinning
      m_master   = 0;
      cfg_master = 1'b0;
      for (int r = 0; r < 3; r++) begin
         int np;
         np = 4 << r;
         cfg_dreq_ratio = 3'(r);
         cfg_domain     = 8'($urandom);
         cfg_id_hi      = $urandom;
         n_dreq = 0;
         n_irq  = 0;
         cfg_offload_en = 1'b1;
         @(negedge clk);
         for (int k = 0; k < np; k++) begin
            tick_en = 1'($urandom);
            pulse_rx();
            repeat (90 + int'($urandom % 20)) @(negedge clk);
         end
         tick_en = 1'b1;
         chk(n_dreq == (np >> r), "R8 Delay_Req thinning", n_dreq, np >> r);
         chk(n_irq == (np >> r), "R9 irq count", n_irq, np >> r);
         cfg_offload_en = 1'b0;
         repeat (5) @(negedge clk);
      end

      // slave with offload off
      n_dreq = 0;
      cfg_dreq_ratio = 3'd0;
      for (int k = 0; k < 3; k++) begin
         pulse_rx();
         repeat (90) @(negedge clk);
      end
      chk(n_dreq == 0, "R8 no Delay_Req while disabled", n_dreq, 0);
      chk(ts_irq == 1'b0, "R9 quiet while disabled", ts_irq, 0);

      done = 1;
      finish_sim();
   end

endmodule